// File: doc/BRIEF.md
# Flash Operation Scheduler with Status Byte

This block sits behind the command decoder of a serial flash memory model. It takes operation launches that are already decoded and works out which of them occupy the memory array. Array operations take a time that is set inside the device. The block models that time with a countdown. The countdown length depends on which duration class the operation falls into.

Only one array operation may be in progress at a time. A second array launch made while one is running is refused with an error pulse, and the running countdown carries on unchanged. Buffer reads and buffer writes never touch the array, so they are accepted at any moment, including during an array operation.

The block keeps a status byte. Bit 7 is set while the array is ready. Bit 6 holds the outcome of the most recent page-versus-buffer compare, taken from an external mismatch input. A status-read request carrying one of the two status-read opcodes returns this byte one cycle later.

Top module: `flash_op_sched`

## Requirements
- R1: After reset the status byte reads 80h (bit 7 = 1 ready, bit 6 = 0), and `op_accept` and `op_reject` are low.
- R2: Kind codes 2 to 10 are array operations: 2 page read, 3 page-to-buffer transfer, 4 page-to-buffer compare, 5 program with erase, 6 program without erase, 7 page erase, 8 block erase, 9 program through buffer, 10 auto rewrite. A launch of one of them while the array is idle gives a one-cycle `op_accept` in the cycle after the launch edge.
- R3: An accepted array operation holds bit 7 at 0 from the launch edge for exactly D+1 cycles, then bit 7 returns to 1. D is taken from the operation's class: T_XFR for codes 2, 3 and 4; T_PE for code 7; T_BE for code 8; T_EP for codes 5, 6, 9 and 10.
- R4: An array launch made while the array is busy gives a one-cycle `op_reject` and no `op_accept`. The running operation still completes at its original time.
- R5: Kind codes 0 (buffer read) and 1 (buffer write) are accepted with `op_accept` both when idle and when busy. They never reject and never make the array busy.
- R6: When a compare (code 4) completes, bit 6 takes the value of `cmp_mismatch` sampled on the completion edge (1 = contents differ, 0 = match). This happens on the same edge on which bit 7 returns to 1.
- R7: Completing any non-compare operation leaves bit 6 unchanged.
- R8: A `sts_req` with `sts_opcode` 57h or D7h gives `sts_valid` in the next cycle. `sts_data` then holds the status byte as it stood before that edge. Any other opcode gives no `sts_valid`.
- R9: Kind codes 11 to 15 are ignored: no accept, no reject and no busy.
- R10: Bits 5 to 0 of the status byte always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Launch strobe for `op_kind` |
| op_kind | input | 4 | Decoded operation code (see R2, R5, R9) |
| cmp_mismatch | input | 1 | Compare outcome from the storage side, 1 = differ |
| op_accept | output | 1 | One-cycle pulse: the launch was taken |
| op_reject | output | 1 | One-cycle pulse: array launch refused while busy |
| sts_req | input | 1 | Status-read request strobe |
| sts_opcode | input | 8 | Opcode that comes with `sts_req` |
| sts_valid | output | 1 | Status-read response valid |
| sts_data | output | 8 | Status byte returned by a read |

## Verification
The bench builds the block with T_XFR=3, T_PE=5, T_BE=9 and T_EP=7. The hardware defaults run to thousands of cycles. With these short values every duration class can be timed to the exact cycle over a full run. Because the four values differ from one another, a class that is mapped to the wrong operation shows up as a wrong busy length. The short block-erase window still leaves room to start a second array launch, a buffer write and a wrong-opcode status read while the erase runs. The bench then confirms that the erase still finishes on time.

// File: rtl/fos_pkg.sv
package fos_pkg;

  typedef enum logic [3:0] {
    K_BUF_RD       = 4'd0,
    K_BUF_WR       = 4'd1,
    K_PG_READ      = 4'd2,
    K_PG_TO_BUF    = 4'd3,
    K_PG_CMP       = 4'd4,
    K_PROG_ERASE   = 4'd5,
    K_PROG_NOERASE = 4'd6,
    K_PG_ERASE     = 4'd7,
    K_BLK_ERASE    = 4'd8,
    K_PROG_THRU    = 4'd9,
    K_AUTO_REWR    = 4'd10
  } op_kind_e;

  typedef enum logic [1:0] {
    CLS_XFR = 2'd0,
    CLS_PE  = 2'd1,
    CLS_BE  = 2'd2,
    CLS_EP  = 2'd3
  } dur_cls_e;

  typedef struct packed {
    logic     known;
    logic     array;
    logic     is_cmp;
    dur_cls_e cls;
  } op_info_t;

  function automatic op_info_t classify(input logic [3:0] kind);
    op_info_t r;
    r = '{known: 1'b1, array: 1'b1, is_cmp: 1'b0, cls: CLS_XFR};
    case (kind)
      K_BUF_RD, K_BUF_WR:                          r.array = 1'b0;
      K_PG_READ, K_PG_TO_BUF:                      r.cls = CLS_XFR;
      K_PG_CMP:                                    r.is_cmp = 1'b1;
      K_PG_ERASE:                                  r.cls = CLS_PE;
      K_BLK_ERASE:                                 r.cls = CLS_BE;
      K_PROG_ERASE, K_PROG_NOERASE,
      K_PROG_THRU, K_AUTO_REWR:                    r.cls = CLS_EP;
      default: begin
        r.known = 1'b0;
        r.array = 1'b0;
      end
    endcase
    return r;
  endfunction

  function automatic logic is_status_opcode(input logic [7:0] opc);
    return (opc == 8'h57) || (opc == 8'hD7);
  endfunction

  function automatic logic [7:0] pack_status(input logic ready, input logic differ);
    return {ready, differ, 6'b000000};
  endfunction

endpackage

// File: rtl/fos_decode.sv
module fos_decode
  import fos_pkg::*;
(
  input  logic       op_valid,
  input  logic [3:0] op_kind,
  input  logic       array_busy,
  output op_info_t   info,
  output logic       start_array,
  output logic       take_launch,
  output logic       refuse_launch
);

  always_comb begin
    info          = classify(op_kind);
    start_array   = op_valid && info.known && info.array && !array_busy;
    refuse_launch = op_valid && info.known && info.array && array_busy;
    take_launch   = op_valid && info.known && !(info.array && array_busy);
  end

endmodule

// File: rtl/fos_timer.sv
module fos_timer
  import fos_pkg::*;
#(
  parameter int unsigned T_XFR = 300,
  parameter int unsigned T_PE  = 2000,
  parameter int unsigned T_BE  = 5000,
  parameter int unsigned T_EP  = 4000,
  parameter int unsigned CNT_W = 13
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  dur_cls_e cls,
  input  logic     start_cmp,
  output logic     busy,
  output logic     done,
  output logic     cmp_fin
);

  logic [CNT_W-1:0] cnt;
  logic             cmp_pend;

  function automatic logic [CNT_W-1:0] class_len(input dur_cls_e c);
    case (c)
      CLS_PE:  return CNT_W'(T_PE);
      CLS_BE:  return CNT_W'(T_BE);
      CLS_EP:  return CNT_W'(T_EP);
      default: return CNT_W'(T_XFR);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cmp_pend <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= class_len(cls);
      cmp_pend <= start_cmp;
    end else if (busy) begin
      if (cnt == '0) begin
        busy     <= 1'b0;
        cmp_pend <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign done    = busy && (cnt == '0);
  assign cmp_fin = done && cmp_pend;

  // R3
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  // R3
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == '0);

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> !$rose(cmp_pend));

endmodule

// File: rtl/fos_status.sv
module fos_status
  import fos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       cmp_fin,
  input  logic       cmp_mismatch,
  input  logic       sts_req,
  input  logic [7:0] sts_opcode,
  output logic       sts_valid,
  output logic [7:0] sts_data
);

  logic       differ_bit;
  logic [7:0] status_now;

  assign status_now = pack_status(!busy, differ_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      differ_bit <= 1'b0;
      sts_valid  <= 1'b0;
      sts_data   <= 8'h00;
    end else begin
      if (cmp_fin) differ_bit <= cmp_mismatch;
      sts_valid <= sts_req && is_status_opcode(sts_opcode);
      if (sts_req && is_status_opcode(sts_opcode)) sts_data <= status_now;
    end
  end

  // R6
  cmp_bit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(differ_bit) |-> $past(cmp_fin));

  // R8
  sts_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> ($past(sts_req) && is_status_opcode($past(sts_opcode))));

  // R10
  sts_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> sts_data[5:0] == 6'd0);

endmodule

// File: rtl/flash_op_sched.sv
module flash_op_sched
  import fos_pkg::*;
#(
  parameter int unsigned T_XFR = 300,
  parameter int unsigned T_PE  = 2000,
  parameter int unsigned T_BE  = 5000,
  parameter int unsigned T_EP  = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op_kind,
  input  logic       cmp_mismatch,
  output logic       op_accept,
  output logic       op_reject,
  input  logic       sts_req,
  input  logic [7:0] sts_opcode,
  output logic       sts_valid,
  output logic [7:0] sts_data
);

  localparam int unsigned MAX_A = (T_XFR > T_PE) ? T_XFR : T_PE;
  localparam int unsigned MAX_B = (T_BE > T_EP) ? T_BE : T_EP;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = (MAX_T < 1) ? 1 : $clog2(MAX_T + 1);

  op_info_t info;
  logic     start_array;
  logic     take_launch;
  logic     refuse_launch;
  logic     array_busy;
  logic     array_done;
  logic     cmp_fin;

  fos_decode u_decode (
    .op_valid      (op_valid),
    .op_kind       (op_kind),
    .array_busy    (array_busy),
    .info          (info),
    .start_array   (start_array),
    .take_launch   (take_launch),
    .refuse_launch (refuse_launch)
  );

  fos_timer #(
    .T_XFR (T_XFR),
    .T_PE  (T_PE),
    .T_BE  (T_BE),
    .T_EP  (T_EP),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_array),
    .cls       (info.cls),
    .start_cmp (info.is_cmp),
    .busy      (array_busy),
    .done      (array_done),
    .cmp_fin   (cmp_fin)
  );

  fos_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (array_busy),
    .cmp_fin      (cmp_fin),
    .cmp_mismatch (cmp_mismatch),
    .sts_req      (sts_req),
    .sts_opcode   (sts_opcode),
    .sts_valid    (sts_valid),
    .sts_data     (sts_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_accept <= 1'b0;
      op_reject <= 1'b0;
    end else begin
      op_accept <= take_launch;
      op_reject <= refuse_launch;
    end
  end

  // R4
  reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |-> $past(array_busy));

  // R4
  accept_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_accept && op_reject));

  // R3
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (array_done && !start_array) |=> !array_busy);

endmodule

// File: tb/test_flash_op_sched.sv
`timescale 1ns/1ps
module test_flash_op_sched;

  localparam int unsigned TX = 3, TP = 5, TB = 9, TE = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_kind = 4'd0;
  logic       cmp_mismatch = 1'b0;
  logic       op_accept, op_reject;
  logic       sts_req = 1'b1;
  logic [7:0] sts_opcode = 8'h57;
  logic       sts_valid;
  logic [7:0] sts_data;

  int n_chk = 0, n_bad = 0, cyc = 0, t_launch = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_op_sched #(.T_XFR(TX), .T_PE(TP), .T_BE(TB), .T_EP(TE)) i_flash_op_sched (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .cmp_mismatch(cmp_mismatch), .op_accept(op_accept), .op_reject(op_reject),
    .sts_req(sts_req), .sts_opcode(sts_opcode), .sts_valid(sts_valid), .sts_data(sts_data)
  );

  typedef struct packed {
    logic [3:0] kind;
    logic       cmp;
    logic [7:0] dur;
    logic       b6;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'd4,  1'b1, 8'(TX), 1'b1},
    '{4'd7,  1'b0, 8'(TP), 1'b1},
    '{4'd8,  1'b0, 8'(TB), 1'b1},
    '{4'd5,  1'b0, 8'(TE), 1'b1},
    '{4'd4,  1'b0, 8'(TX), 1'b0},
    '{4'd2,  1'b1, 8'(TX), 1'b0},
    '{4'd9,  1'b1, 8'(TE), 1'b0},
    '{4'd10, 1'b1, 8'(TE), 1'b0},
    '{4'd3,  1'b1, 8'(TX), 1'b0},
    '{4'd6,  1'b1, 8'(TE), 1'b0},
    '{4'd4,  1'b1, 8'(TX), 1'b1}
  };

  function automatic int exp_busy_span(input int d);
    return d + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [3:0] k);
    @(negedge clk);
    op_valid = 1'b1;
    op_kind  = k;
    @(negedge clk);
    op_valid = 1'b0;
    t_launch = cyc;
  endtask

  task automatic wait_ready(output int span);
    span = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sts_valid && sts_data[7]) begin
        span = cyc - t_launch;
        break;
      end
    end
  endtask

  initial begin
    int span;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk(sts_valid && sts_data == 8'h80, "R1 status after reset", sts_data, 8'h80);
    chk(!op_accept && !op_reject, "R1 no pulses after reset", {op_accept, op_reject}, 0);

    for (int v = 0; v < NV; v++) begin
      sts_opcode   = v[0] ? 8'hD7 : 8'h57;
      cmp_mismatch = VEC[v].cmp;
      launch(VEC[v].kind);
      chk(op_accept && !op_reject, "R2 accept array launch", {op_accept, op_reject}, 2);
      wait_ready(span);
      chk(span == exp_busy_span(int'(VEC[v].dur)), "R3 busy length", span,
          exp_busy_span(int'(VEC[v].dur)));
      chk(sts_data[6] == VEC[v].b6, "R6 R7 compare bit", sts_data[6], VEC[v].b6);
      chk(sts_data[5:0] == 6'd0, "R10 low bits", sts_data[5:0], 0);
    end
    sts_opcode = 8'h57;

    // R4 reject while busy, with R5 buffer ops alongside
    cmp_mismatch = 1'b0;
    launch(4'd8);
    t0 = t_launch;
    chk(op_accept, "R2 block erase accepted", op_accept, 1);
    launch(4'd7);
    chk(op_reject && !op_accept, "R4 reject while busy", {op_accept, op_reject}, 1);
    @(negedge clk);
    chk(!op_reject, "R4 reject is one cycle", op_reject, 0);
    launch(4'd1);
    chk(op_accept && !op_reject, "R5 buffer write while busy", {op_accept, op_reject}, 2);
    launch(4'd0);
    chk(op_accept && !op_reject, "R5 buffer read while busy", {op_accept, op_reject}, 2);
    // R8 wrong opcode gives no response
    @(negedge clk);
    sts_opcode = 8'h54;
    @(negedge clk);
    chk(!sts_valid, "R8 other opcode ignored", sts_valid, 0);
    sts_opcode = 8'hD7;
    @(negedge clk);
    chk(sts_valid && !sts_data[7], "R8 D7 read shows busy", sts_data, 8'h00);
    t_launch = t0;
    wait_ready(span);
    chk(span == exp_busy_span(TB), "R4 running erase time unchanged", span, exp_busy_span(TB));
    chk(sts_data[6] == 1'b1, "R7 erase keeps compare bit", sts_data[6], 1);

    // R5 buffer op while idle makes no busy
    launch(4'd1);
    chk(op_accept, "R5 buffer write idle", op_accept, 1);
    @(negedge clk);
    @(negedge clk);
    chk(sts_data[7], "R5 no busy from buffer op", sts_data, 8'hC0);

    // R9 unknown kinds
    for (int k = 11; k < 16; k++) begin
      launch(4'(k));
      chk(!op_accept && !op_reject, "R9 unknown kind ignored", {op_accept, op_reject}, 0);
      @(negedge clk);
      @(negedge clk);
      chk(sts_data[7], "R9 no busy from unknown kind", sts_data, 8'hC0);
    end

    // R8 read sampled before a launch edge shows ready
    @(negedge clk);
    op_valid = 1'b1;
    op_kind  = 4'd2;
    @(negedge clk);
    op_valid = 1'b0;
    chk(sts_valid && sts_data == 8'hC0, "R8 byte before launch edge", sts_data, 8'hC0);
    @(negedge clk);
    chk(sts_valid && sts_data == 8'h40, "R8 byte after launch edge", sts_data, 8'h40);
    repeat (10) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule